// File: doc/BRIEF.md
# Multichannel Hold-Array Refresh Sequencer

This block drives a bank of sample-and-hold channels that share one DAC. It walks a 32-entry code memory in a loop. For each channel it presents the stored 12-bit code on the DAC bus and then strobes that channel so the channel acquires the settled DAC voltage. One channel is handled per tick. A tick is four sub-phases. The sub-phases come either from an internal divider or from the rising edges of a free external clock. If the external clock stops, the whole sequencer freezes and every output holds its value.

A host serial port writes codes into the same memory. It tells this block when a frame is open, when each word finishes, the address of that word, and two per-word control bits. While a frame is open, refresh stops and the channel that was in progress is kept. After the frame closes, the block acts according to the update mode:

- In burst mode it resumes scanning at the kept channel, and new codes take effect when their turn comes.
- In immediate mode it first finishes the current tick, then spends one tick on the channel written last, and then resumes at the kept channel.

After reset the block runs an initialisation pass that cannot be interrupted. This pass writes a default code to every memory entry and refreshes every channel in order.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset the block writes 0x4F3 to memory addresses 0 to 31 in ascending order. Each channel is strobed once in the same order, and dacCode reads 0x4F3 at every strobe.
- R2: The initialisation pass always uses the internal divider, whatever forceExtClk is set to. The frame flag and any completed words are ignored during this pass, including their mode bits.
- R3: In sequence mode the channels are strobed in ascending order, one per tick, wrapping from 31 to 0. At each strobe, dacCode equals the code stored for that channel.
- R4: A tick is four sub-phases. With the external clock selected, each rising edge of extClk is one sub-phase. The strobe of a tick follows its fourth edge and never its third.
- R5: The external clock is selected when forceExtClk is 1, or when the wrExtBit of the last accepted word is 1. With the external clock selected and extClk idle, there are no strobes and dacCode holds.
- R6: sampleStrobe has at most one bit set, and each strobe lasts one clock cycle.
- R7: While frameActive is 1, outside initialisation, no channel is strobed.
- R8: In burst mode, after frameActive falls, refresh restarts at the next tick boundary with the channel that was in progress when the frame opened. The full loop, including all new codes, is complete within 33 ticks.
- R9: A word with wrImmBit=1, or a word accepted while forceImmed=1, requests an immediate update. After the frame closes, the rest of the current tick runs with no strobe. The next tick strobes the last immediately written address with its new code, and scanning then resumes at the interrupted channel.
- R10: busy is 1 throughout initialisation and from an immediate request until its strobe. busy is 0 in plain scanning.
- R11: With the internal divider selected, one sub-phase lasts INT_DIV clock cycles, so consecutive strobes are 4*INT_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset; starts the initialisation pass on release |
| frameActive | input | 1 | Host serial frame open (refresh suspended) |
| wrDone | input | 1 | One-cycle pulse when a host word has been stored |
| wrAddr | input | 5 | Address of the completed word |
| wrImmBit | input | 1 | Per-word immediate-update request |
| wrExtBit | input | 1 | Per-word external-clock select |
| forceImmed | input | 1 | Pin-level immediate-update select |
| forceExtClk | input | 1 | Pin-level external-clock select |
| extClk | input | 1 | External sub-phase clock, sampled by clk |
| memRdData | input | 12 | Code memory read data, one cycle after memAddr |
| memAddr | output | 5 | Code memory address |
| memWrEn | output | 1 | Memory write enable for the default code |
| memWrData | output | 12 | Default code to write |
| dacCode | output | 12 | Code presented to the DAC |
| sampleStrobe | output | 32 | One-hot acquire strobe per channel |
| busy | output | 1 | Initialisation or immediate update pending |

## Verification
The assertions take the following for granted about the inputs:
- wrDone is a single-cycle pulse that occurs only while frameActive is high.
- extClk stays high and low for several clk cycles each, so the synchronised sub-phase pulses are at least two cycles apart.
- Once the memory is initialised, it returns the stored code one cycle after the address.

The stimulus respects all of these. Every input changes on the falling clock edge, each host word is issued inside an open frame, and extClk is held at each level for three clk cycles.

// File: rtl/refseq_pkg.sv
package refseq_pkg;
  parameter int unsigned CH_BITS   = 5;
  parameter int unsigned CODE_BITS = 12;
  localparam int unsigned NUM_CH   = 1 << CH_BITS;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_SCAN,
    ST_HOLD,
    ST_WAIT,
    ST_IMM
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic [CH_BITS-1:0] chan;
    logic               fire;
    logic               useDefault;
    logic               loadCode;
  } seqCtl_t;
endpackage

// File: rtl/refseq_timebase.sv
module refseq_timebase #(
  parameter int unsigned INT_DIV = 125
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  input  logic useInternal,
  output logic phasePulse
);
  localparam int unsigned DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int unsigned SYNC_STAGES = 3;

  logic [SYNC_STAGES-1:0] extSync;
  logic [DIV_W-1:0]       divCnt;
  logic                   divWrap;
  logic                   extRise;

  assign divWrap = (divCnt == DIV_W'(INT_DIV - 1));
  assign extRise = extSync[SYNC_STAGES-2] & ~extSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
    end else begin
      extSync <= {extSync[SYNC_STAGES-2:0], extClk};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!useInternal || divWrap) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phasePulse <= 1'b0;
    end else begin
      phasePulse <= useInternal ? divWrap : extRise;
    end
  end
endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               phasePulse,
  input  logic               frameActive,
  input  logic               wrDone,
  input  logic [CH_BITS-1:0] wrAddr,
  input  logic               wrImmBit,
  input  logic               wrExtBit,
  input  logic               forceImmed,
  input  logic               forceExtClk,
  output seqCtl_t            ctl,
  output logic               useInternal,
  output logic               busy
);
  localparam logic [CH_BITS-1:0] CH_LAST = CH_BITS'(NUM_CH - 1);

  seqState_t          state, stateNext;
  logic [1:0]         phaseCnt;
  logic [CH_BITS-1:0] curCh;
  logic [CH_BITS-1:0] immAddr;
  logic               immReq;
  logic               extBit;
  logic               tickEnd, atBoundary, wordOk, immWord;
  logic               scanLive, advance;

  assign tickEnd    = phasePulse && (phaseCnt == 2'd3);
  assign atBoundary = tickEnd || ((phaseCnt == 2'd0) && !phasePulse);
  assign wordOk     = wrDone && (state != ST_INIT);
  assign immWord    = wordOk && (forceImmed || wrImmBit);
  assign scanLive   = ((state == ST_SCAN) || (state == ST_IMM)) && !frameActive;
  assign advance    = tickEnd && ((state == ST_INIT) || ((state == ST_SCAN) && !frameActive));

  always_comb begin
    stateNext = state;
    case (state)
      ST_INIT: if (tickEnd && (curCh == CH_LAST)) stateNext = ST_SCAN;
      ST_SCAN: begin
        if (frameActive)             stateNext = ST_HOLD;
        else if (tickEnd && immReq)  stateNext = ST_IMM;
      end
      ST_HOLD: begin
        if (!frameActive) begin
          if (atBoundary) stateNext = immReq ? ST_IMM : ST_SCAN;
          else            stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (frameActive)  stateNext = ST_HOLD;
        else if (tickEnd) stateNext = immReq ? ST_IMM : ST_SCAN;
      end
      ST_IMM: begin
        if (frameActive)  stateNext = ST_HOLD;
        else if (tickEnd) stateNext = ST_SCAN;
      end
      default: stateNext = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_INIT;
      phaseCnt <= 2'd0;
      curCh    <= '0;
    end else begin
      state <= stateNext;
      if (phasePulse) phaseCnt <= phaseCnt + 2'd1;
      if (advance)    curCh    <= curCh + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      immAddr <= '0;
      immReq  <= 1'b0;
      extBit  <= 1'b0;
    end else begin
      if (wordOk) extBit <= wrExtBit;
      if (immWord) begin
        immAddr <= wrAddr;
        immReq  <= 1'b1;
      end else if ((state == ST_IMM) && tickEnd && !frameActive) begin
        immReq  <= 1'b0;
      end
    end
  end

  assign useInternal    = (state == ST_INIT) || !(forceExtClk || extBit);
  assign busy           = (state == ST_INIT) || immReq;
  assign ctl.chan       = (state == ST_IMM) ? immAddr : curCh;
  assign ctl.fire       = tickEnd && ((state == ST_INIT) || scanLive);
  assign ctl.useDefault = (state == ST_INIT);
  assign ctl.loadCode   = (state == ST_SCAN) || (state == ST_IMM);
endmodule

// File: rtl/refseq_datapath.sv
module refseq_datapath
  import refseq_pkg::*;
#(
  parameter logic [CODE_BITS-1:0] DEF_CODE = 12'h4F3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic [CODE_BITS-1:0] memRdData,
  output logic [CH_BITS-1:0]   memAddr,
  output logic                 memWrEn,
  output logic [CODE_BITS-1:0] memWrData,
  output logic [CODE_BITS-1:0] dacCode,
  output logic [NUM_CH-1:0]    sampleStrobe
);
  logic [NUM_CH-1:0] strobeNext;

  assign memAddr   = ctl.chan;
  assign memWrEn   = ctl.useDefault;
  assign memWrData = DEF_CODE;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign strobeNext[g] = ctl.fire && (ctl.chan == CH_BITS'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode      <= '0;
      sampleStrobe <= '0;
    end else begin
      sampleStrobe <= strobeNext;
      if (ctl.useDefault)    dacCode <= DEF_CODE;
      else if (ctl.loadCode) dacCode <= memRdData;
    end
  end
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refseq_pkg::*;
#(
  parameter int unsigned          INT_DIV  = 125,
  parameter logic [CODE_BITS-1:0] DEF_CODE = 12'h4F3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameActive,
  input  logic                 wrDone,
  input  logic [CH_BITS-1:0]   wrAddr,
  input  logic                 wrImmBit,
  input  logic                 wrExtBit,
  input  logic                 forceImmed,
  input  logic                 forceExtClk,
  input  logic                 extClk,
  input  logic [CODE_BITS-1:0] memRdData,
  output logic [CH_BITS-1:0]   memAddr,
  output logic                 memWrEn,
  output logic [CODE_BITS-1:0] memWrData,
  output logic [CODE_BITS-1:0] dacCode,
  output logic [NUM_CH-1:0]    sampleStrobe,
  output logic                 busy
);
  seqCtl_t ctl;
  logic    useInternal;
  logic    phasePulse;

  refseq_timebase #(.INT_DIV(INT_DIV)) timebase_i (
    .clk(clk), .rstN(rstN), .extClk(extClk),
    .useInternal(useInternal), .phasePulse(phasePulse)
  );

  refseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .phasePulse(phasePulse),
    .frameActive(frameActive), .wrDone(wrDone), .wrAddr(wrAddr),
    .wrImmBit(wrImmBit), .wrExtBit(wrExtBit),
    .forceImmed(forceImmed), .forceExtClk(forceExtClk),
    .ctl(ctl), .useInternal(useInternal), .busy(busy)
  );

  refseq_datapath #(.DEF_CODE(DEF_CODE)) datapath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .dacCode(dacCode), .sampleStrobe(sampleStrobe)
  );
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk
  import refseq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               frameActive,
  input logic               memWrEn,
  input logic [CH_BITS-1:0] memAddr,
  input logic [NUM_CH-1:0]  sampleStrobe,
  input logic               busy
);
  a_r6_onehot_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sampleStrobe));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (|sampleStrobe) |=> (sampleStrobe == '0));

  a_r7_quiet_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameActive) && !$past(memWrEn)) |-> (sampleStrobe == '0));

  a_r1_init_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn) && (memAddr != $past(memAddr)))
      |-> (memAddr == $past(memAddr) + 1'b1));

  a_r10_busy_in_init: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy);
endmodule

bind refresh_sequencer refresh_sequencer_chk chk_i (
  .clk(clk), .rstN(rstN), .frameActive(frameActive), .memWrEn(memWrEn),
  .memAddr(memAddr), .sampleStrobe(sampleStrobe), .busy(busy)
);

// File: tb/refresh_sequencer_tb_top.sv
module refresh_sequencer_tb_top;
  import refseq_pkg::*;

  localparam int unsigned TB_DIV  = 125;
  localparam int unsigned TICK_CY = 4 * TB_DIV;
  localparam logic [11:0] DEFC    = 12'h4F3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameActive = 1'b0, wrDone = 1'b0, wrImmBit = 1'b0, wrExtBit = 1'b0;
  logic forceImmed = 1'b0, forceExtClk = 1'b1, extClk = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [11:0] memRdData;
  logic [4:0]  memAddr;
  logic        memWrEn;
  logic [11:0] memWrData;
  logic [11:0] dacCode;
  logic [31:0] sampleStrobe;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  logic [11:0] bMem [32];
  int logCh  [64];
  int logCode[64];
  int logCyc [64];
  int logN = 0;

  always #10 clk = ~clk;

  refresh_sequencer #(.INT_DIV(TB_DIV), .DEF_CODE(DEFC)) dut_i (
    .clk(clk), .rstN(rstN), .frameActive(frameActive), .wrDone(wrDone),
    .wrAddr(wrAddr), .wrImmBit(wrImmBit), .wrExtBit(wrExtBit),
    .forceImmed(forceImmed), .forceExtClk(forceExtClk), .extClk(extClk),
    .memRdData(memRdData), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .dacCode(dacCode), .sampleStrobe(sampleStrobe),
    .busy(busy)
  );

  // code memory model: synchronous read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memWrEn) bMem[memAddr] <= memWrData;
    memRdData <= bMem[memAddr];
  end

  // strobe monitor
  always @(negedge clk) begin
    if (sampleStrobe != '0 && logN < 64) begin
      for (int i = 0; i < 32; i++) if (sampleStrobe[i]) logCh[logN] = i;
      logCode[logN] = dacCode;
      logCyc[logN]  = cyc;
      logN = logN + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic extEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic hostWord(input int a, input logic [11:0] code, input logic imm, input logic ext);
    @(negedge clk);
    wrAddr = 5'(a); wrImmBit = imm; wrExtBit = ext; wrDone = 1'b1;
    bMem[a] = code;
    @(negedge clk);
    wrDone = 1'b0;
  endtask

  task automatic frameOpen();
    @(negedge clk) frameActive = 1'b1;
  endtask

  task automatic frameClose();
    @(negedge clk) frameActive = 1'b0;
  endtask

  task automatic testInit();
    int ok;
    for (int i = 0; i < 32; i++) bMem[i] = 12'h000;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 busy at init start", busy, 1);
    repeat (1000) @(negedge clk);
    // activity during init must be ignored (R2)
    @(negedge clk) frameActive = 1'b1;
    @(negedge clk);
    wrAddr = 5'd5; wrImmBit = 1'b1; wrExtBit = 1'b1; wrDone = 1'b1;
    @(negedge clk) wrDone = 1'b0;
    repeat (20) @(negedge clk);
    frameActive = 1'b0;
    wrImmBit = 1'b0; wrExtBit = 1'b0;
    for (int i = 0; i < 40000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R1 init strobe count", logN, 32);
    ok = 1;
    for (int i = 0; i < 32; i++) if (logCh[i] != i || logCode[i] != DEFC) ok = 0;
    chk("R1 init order and code", ok, 1);
    ok = 1;
    for (int i = 0; i < 32; i++) if (bMem[i] != DEFC) ok = 0;
    chk("R1 memory defaulted", ok, 1);
    chk("R2 R11 init tick spacing", logCyc[1] - logCyc[0], TICK_CY);
    chk("R10 busy after init", busy, 0);
  endtask

  task automatic testStopped();
    logN = 0;
    repeat (1000) @(negedge clk);
    chk("R5 no strobe with idle external clock", logN, 0);
    chk("R5 dacCode holds", dacCode, DEFC);
  endtask

  task automatic testSequenceBurst();
    int ok;
    logN = 0;
    extEdges(3);
    chk("R4 no strobe after three edges", logN, 0);
    extEdges(1);
    chk("R4 strobe after fourth edge", logN, 1);
    chk("R3 first channel", logCh[0], 0);
    extEdges(12);
    chk("R3 three more ticks", logN, 4);
    extEdges(2);
    logN = 0;
    frameOpen();
    hostWord(2, 12'h111, 1'b0, 1'b0);
    hostWord(9, 12'h222, 1'b0, 1'b0);
    hostWord(31, 12'hABC, 1'b0, 1'b0);
    extEdges(8);
    chk("R7 no strobe during frame", logN, 0);
    frameClose();
    chk("R10 busy low in burst", busy, 0);
    extEdges(2 + 4 * 33);
    chk("R8 resume count 33 ticks", logN, 33);
    chk("R8 resume at interrupted channel", logCh[0], 4);
    ok = 1;
    for (int i = 0; i < 33; i++) if (logCh[i] != (4 + i) % 32) ok = 0;
    chk("R3 ascending with wrap", ok, 1);
    ok = 1;
    for (int i = 0; i < 33; i++) if (logCode[i] != bMem[logCh[i]]) ok = 0;
    chk("R3 R8 codes match stored values", ok, 1);
    chk("R8 new code ch31", logCode[27], 12'hABC);
  endtask

  task automatic testImmediate();
    logN = 0;
    extEdges(1);
    frameOpen();
    hostWord(20, 12'h7E5, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10 busy on immediate request", busy, 1);
    frameClose();
    extEdges(3);
    chk("R9 no strobe in tick remainder", logN, 0);
    chk("R10 busy while pending", busy, 1);
    extEdges(4);
    chk("R9 immediate strobe count", logN, 1);
    chk("R9 immediate channel", logCh[0], 20);
    chk("R9 immediate code", logCode[0], 12'h7E5);
    chk("R10 busy cleared", busy, 0);
    extEdges(4);
    chk("R9 resume at interrupted channel", logCh[1], 5);
    // pin-level immediate select
    logN = 0;
    forceImmed = 1'b1;
    frameOpen();
    hostWord(3, 12'h0F0, 1'b0, 1'b0);
    frameClose();
    forceImmed = 1'b0;
    extEdges(4);
    chk("R9 pin immediate channel", logCh[0], 3);
    chk("R9 pin immediate code", logCode[0], 12'h0F0);
    extEdges(4);
    chk("R9 pin resume channel", logCh[1], 6);
  endtask

  task automatic testClockSelect();
    logN = 0;
    forceExtClk = 1'b0;
    repeat (3 * TICK_CY + 50) @(negedge clk);
    chk("R2 init mode bit ignored, internal runs", (logN >= 2) ? 1 : 0, 1);
    chk("R3 internal continues at channel 7", logCh[0], 7);
    chk("R11 internal tick spacing", logCyc[1] - logCyc[0], TICK_CY);
    frameOpen();
    hostWord(0, DEFC, 1'b0, 1'b1);
    frameClose();
    logN = 0;
    repeat (3 * TICK_CY) @(negedge clk);
    chk("R5 word selects external clock", logN, 0);
    frameOpen();
    hostWord(0, DEFC, 1'b0, 1'b0);
    frameClose();
    repeat (3 * TICK_CY) @(negedge clk);
    chk("R5 word returns to internal", (logN >= 1) ? 1 : 0, 1);
  endtask

  initial begin
    testInit();
    testStopped();
    testSequenceBurst();
    testImmediate();
    testClockSelect();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule